// File: doc/BRIEF.md
# Power-On and Hard Reset Sequencer

This block runs the reset flows of a device from a single system clock. A power-on request arrives on an active-low pin that can fall at any moment with no relation to the clock. The request is caught at once, but it starts the power-on flow only if it stays asserted long enough. A qualified power-on flow keeps the internal reset asserted and pulls the shared hard-reset line low. When the request goes away, the block issues one load strobe for the reset configuration word. It then holds the hard reset for a fixed number of cycles and releases the line.

The hard-reset line is a wired open-drain net. The block never drives it high. It only enables a pull-down, and a board pull-up supplies the high level. When the block is not pulling the line down, it watches the line through a synchronizer. A low level from another agent then starts a hard-reset flow. That flow runs the same hold and release steps as the power-on flow but skips the configuration load. Each flow starts with a one-cycle abort request so that pending transactions are dropped.

Top module: `rst_seq_top`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `hr_drive_o`, `core_rst_o`, `cfg_load_o` and `abort_o` are all 0.
- R2: A low level on `por_ni` sets the power-on synchronizer asynchronously, so the request is visible at the first rising edge that sees the pin low. With the two-cycle synchronizer release, a pin pulse that stays low across 30 rising edges counts as 32 qualifying cycles and is accepted.
- R3: The power-on flow starts only after the synchronized request has stayed high for QUAL_CYC (default 32) consecutive edges. A pin pulse that stays low across 29 or fewer rising edges leaves every output at 0.
- R4: From qualification until the request is released, `hr_drive_o` and `core_rst_o` are 1 and `cfg_load_o` is 0.
- R5: A qualified power-on flow raises `cfg_load_o` for exactly one cycle, in the cycle after the synchronized request is released. `hr_drive_o` is 1 in that cycle.
- R6: After the load cycle of a power-on flow, or from the start of a hard-reset flow, `hr_drive_o` stays 1 for exactly HOLD_CYC (default 64) cycles and then goes to 0.
- R7: `core_rst_o` is 1 whenever `hr_drive_o` is 1. It stays 1 in the cycle where `hr_drive_o` falls and goes to 0 in the cycle after.
- R8: While the block is idle, a low level on `hr_pin_i` starts a hard-reset flow. `hr_drive_o` rises in the third cycle after the pin is first sampled low. This flow never pulses `cfg_load_o`.
- R9: `abort_o` is a one-cycle pulse in the first cycle of each stretch where `hr_drive_o` is 1, and it is 0 at all other times.
- R10: For SYNC_STAGES cycles after the block releases the pin, any low level still in the synchronizer is ignored, so the block's own drive never restarts a flow. A line that an outside agent still holds low after that blanking window starts a new flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the sequencer's own registers |
| por_ni | input | 1 | Power-on request pin, active low, asynchronous |
| hr_pin_i | input | 1 | Sampled level of the open-drain hard-reset line |
| hr_drive_o | output | 1 | Pull-down enable for the hard-reset line (1 = pull low, 0 = high impedance) |
| core_rst_o | output | 1 | Internal reset for core registers, active high |
| cfg_load_o | output | 1 | One-cycle strobe that loads the reset configuration word |
| abort_o | output | 1 | One-cycle request to abort all pending transactions |

## Verification
The assertions check several rules on every cycle. The power-on request must be captured on any cycle the pin is low. The abort and load strobes must be single-cycle. The internal reset must cover the line drive and trail it by exactly one cycle. The qualification threshold, the hold length, the blanking after release and the retrigger by an outside agent depend on pulse lengths and counts. These show up only in the bench's scenarios: pin pulses of 20, 29, 30 and 50 cycles, and short and long external assertions, all compared with a behavioural reference model on every clock.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POR_QUAL,
    ST_CFG_LOAD,
    ST_HR_HOLD,
    ST_RELEASE
  } seq_state_e;
endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          RST_VAL  = 1'b0,
  parameter bit          HAS_ASET = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic aset_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (HAS_ASET) begin : g_aset
      // asynchronous set catches the request without a clock edge
      always_ff @(posedge clk_i or negedge rst_ni or negedge aset_ni) begin
        if (!rst_ni)       ff_q <= {STAGES{RST_VAL}};
        else if (!aset_ni) ff_q <= '1;
        else               ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end else begin : g_plain
      logic unused_aset;
      assign unused_aset = aset_ni;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int unsigned QUAL_CYC    = 32,
  parameter int unsigned HOLD_CYC    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_act_i,
  input  logic       hr_low_i,
  output seq_state_e state_o,
  output logic       qualified_o
);
  localparam int unsigned MAXC = (QUAL_CYC > HOLD_CYC) ? QUAL_CYC : HOLD_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned BW   = $clog2(SYNC_STAGES + 1);
  localparam logic [CW-1:0] QUAL_MAX = CW'(QUAL_CYC);
  localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CYC - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] blank_q, blank_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      blank_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      blank_q <= blank_d;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    blank_d = blank_q;
    unique case (state_q)
      ST_IDLE: begin
        if (blank_q != '0) blank_d = blank_q - BW'(1);
        if (por_act_i) begin
          state_d = ST_POR_QUAL;
          cnt_d   = CW'(1);
        end else if (hr_low_i && blank_q == '0) begin
          state_d = ST_HR_HOLD;
          cnt_d   = '0;
        end
      end
      ST_POR_QUAL: begin
        if (por_act_i) begin
          if (cnt_q != QUAL_MAX) cnt_d = cnt_q + CW'(1);
        end else if (cnt_q == QUAL_MAX) begin
          state_d = ST_CFG_LOAD;
          cnt_d   = '0;
        end else begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      end
      ST_CFG_LOAD: begin
        state_d = ST_HR_HOLD;
        cnt_d   = '0;
      end
      ST_HR_HOLD: begin
        if (cnt_q == HOLD_END) begin
          state_d = ST_RELEASE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_RELEASE: begin
        state_d = ST_IDLE;
        blank_d = BW'(SYNC_STAGES);  // mask own drive still in the synchronizer
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_o     = state_q;
  assign qualified_o = (state_q == ST_POR_QUAL) && (cnt_q == QUAL_MAX);
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int unsigned QUAL_CYC    = 32,
  parameter int unsigned HOLD_CYC    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  input  logic hr_pin_i,
  output logic hr_drive_o,
  output logic core_rst_o,
  output logic cfg_load_o,
  output logic abort_o
);
  logic       por_act;
  logic       hr_sync;
  logic       qualified;
  logic       drive_q;
  seq_state_e state;

  rst_seq_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0),
    .HAS_ASET(1'b1)
  ) u_por_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .aset_ni(por_ni),
    .d_i    (1'b0),
    .q_o    (por_act)
  );

  rst_seq_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1),
    .HAS_ASET(1'b0)
  ) u_hr_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .aset_ni(1'b1),
    .d_i    (hr_pin_i),
    .q_o    (hr_sync)
  );

  rst_seq_fsm #(
    .QUAL_CYC   (QUAL_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_act_i  (por_act),
    .hr_low_i   (~hr_sync),
    .state_o    (state),
    .qualified_o(qualified)
  );

  assign hr_drive_o = qualified || (state == ST_CFG_LOAD) || (state == ST_HR_HOLD);
  assign core_rst_o = hr_drive_o || (state == ST_RELEASE);
  assign cfg_load_o = (state == ST_CFG_LOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_q <= 1'b0;
    else         drive_q <= hr_drive_o;
  end

  assign abort_o = hr_drive_o && !drive_q;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic por_ni,
  input logic por_act,
  input logic hr_drive_o,
  input logic core_rst_o,
  input logic cfg_load_o,
  input logic abort_o
);
  a_r2_por_caught: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ni |-> por_act);

  a_r5_cfg_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_o |=> !cfg_load_o && hr_drive_o);

  a_r5_cfg_in_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_o |-> hr_drive_o && !abort_o);

  a_r7_core_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hr_drive_o |-> core_rst_o);

  a_r7_core_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hr_drive_o) |-> core_rst_o ##1 !core_rst_o);

  a_r9_abort_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> hr_drive_o && !$past(hr_drive_o));

  a_r9_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
endmodule

bind rst_seq_top rst_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .por_ni    (por_ni),
  .por_act   (por_act),
  .hr_drive_o(hr_drive_o),
  .core_rst_o(core_rst_o),
  .cfg_load_o(cfg_load_o),
  .abort_o   (abort_o)
);

// File: tb/rst_seq_top_tb.sv
module rst_seq_top_tb;
  localparam int Q = 32;
  localparam int H = 64;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic por_ni = 1'b1;
  logic ext_low = 1'b0;
  logic hr_pin_i;
  logic hr_drive_o, core_rst_o, cfg_load_o, abort_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  assign hr_pin_i = (ext_low || hr_drive_o) ? 1'b0 : 1'b1;

  rst_seq_top u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .por_ni    (por_ni),
    .hr_pin_i  (hr_pin_i),
    .hr_drive_o(hr_drive_o),
    .core_rst_o(core_rst_o),
    .cfg_load_o(cfg_load_o),
    .abort_o   (abort_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: phase 0 idle, 1 qualify, 2 load, 3 hold, 4 release
  int ph = 0, cnt = 0, blank = 0, hi_cnt = 2;
  bit h1 = 1, h2 = 1, m_prev = 0;
  bit e_drv = 0, e_core = 0, e_cfg = 0, e_abort = 0;

  function automatic bit mdrv(input int p, input int c);
    return (p == 1 && c == Q) || p == 2 || p == 3;
  endfunction

  // scenario observers
  int cfg_tot = 0, abort_tot = 0, run = 0, last_run = -1, gap = 0, last_gap = -1;
  bit in_gap = 0, prev_d = 0;

  always @(posedge clk_i) begin
    bit pin_pre, pact, hlow, dcur;
    int b0;
    if (!rst_ni) begin
      ph = 0; cnt = 0; blank = 0; hi_cnt = 2; h1 = 1; h2 = 1; m_prev = 0;
    end else begin
      dcur = mdrv(ph, cnt);
      pin_pre = !(ext_low || dcur);
      pact = !por_ni || hi_cnt < 2;
      if (!por_ni) hi_cnt = 0; else if (hi_cnt < 2) hi_cnt++;
      hlow = !h2;
      h2 = h1; h1 = pin_pre;
      m_prev = dcur;
      b0 = blank;
      case (ph)
        0: begin
          if (blank > 0) blank--;
          if (pact) begin ph = 1; cnt = 1; end
          else if (hlow && b0 == 0) begin ph = 3; cnt = 0; end
        end
        1: begin
          if (pact) begin if (cnt < Q) cnt++; end
          else if (cnt == Q) begin ph = 2; cnt = 0; end
          else begin ph = 0; cnt = 0; end
        end
        2: begin ph = 3; cnt = 0; end
        3: begin if (cnt == H - 1) begin ph = 4; cnt = 0; end else cnt++; end
        default: begin ph = 0; blank = 2; end
      endcase
    end
    e_drv   = mdrv(ph, cnt);
    e_core  = e_drv || ph == 4;
    e_cfg   = ph == 2;
    e_abort = e_drv && !m_prev;
    #2;
    if (rst_ni && !done) begin
      chk(hr_drive_o == e_drv, "R4", "hr_drive_o", hr_drive_o, e_drv);
      chk(core_rst_o == e_core, "R7", "core_rst_o", core_rst_o, e_core);
      chk(cfg_load_o == e_cfg, "R5", "cfg_load_o", cfg_load_o, e_cfg);
      chk(abort_o == e_abort, "R9", "abort_o", abort_o, e_abort);
    end
    cfg_tot += int'(cfg_load_o);
    abort_tot += int'(abort_o);
    if (cfg_load_o) run = 0;
    else if (hr_drive_o) run++;
    if (prev_d && !hr_drive_o) begin last_run = run; run = 0; in_gap = 1; gap = 0; end
    if (in_gap) begin
      if (core_rst_o) gap++;
      else begin last_gap = gap; in_gap = 0; end
    end
    prev_d = hr_drive_o;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic por_pulse(input int len);
    @(negedge clk_i);
    por_ni = 1'b0;
    cyc(len);
    por_ni = 1'b1;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    int c0, a0;
    #1 rst_ni = 1'b0;
    cyc(3);
    // R1 reset state
    chk({hr_drive_o, core_rst_o, cfg_load_o, abort_o} == 4'b0, "R1", "outputs in reset",
        {hr_drive_o, core_rst_o, cfg_load_o, abort_o}, 0);
    chk(hr_pin_i == 1'b1, "R1", "pin released", hr_pin_i, 1);
    rst_ni = 1'b1;
    cyc(2);
    chk({hr_drive_o, core_rst_o, cfg_load_o, abort_o} == 4'b0, "R1", "outputs after reset",
        {hr_drive_o, core_rst_o, cfg_load_o, abort_o}, 0);

    // R3 short pulses rejected
    a0 = abort_tot; c0 = cfg_tot;
    por_pulse(20); cyc(40);
    por_pulse(29); cyc(40);
    chk(abort_tot == a0, "R3", "flows from short pulses", abort_tot - a0, 0);
    chk(cfg_tot == c0, "R3", "loads from short pulses", cfg_tot - c0, 0);
    chk(core_rst_o == 1'b0, "R3", "core reset after short pulses", core_rst_o, 0);

    // R2 30-edge pulse accepted thanks to asynchronous capture
    a0 = abort_tot; c0 = cfg_tot;
    por_pulse(30); cyc(120);
    chk(abort_tot - a0 == 1, "R2", "flows from 30-cycle pulse", abort_tot - a0, 1);
    chk(cfg_tot - c0 == 1, "R5", "load strobes", cfg_tot - c0, 1);
    chk(last_run == H, "R6", "hold after load", last_run, H);
    chk(last_gap == 1, "R7", "core reset tail", last_gap, 1);

    // R4 held drive during a long request
    @(negedge clk_i);
    por_ni = 1'b0;
    cyc(40);
    chk(hr_drive_o && core_rst_o && !cfg_load_o, "R4", "drive while request held",
        {hr_drive_o, core_rst_o, cfg_load_o}, 3'b110);
    cyc(10);
    por_ni = 1'b1;
    cyc(120);

    // R8 external hard reset, no load; R10 no self retrigger
    a0 = abort_tot; c0 = cfg_tot;
    @(negedge clk_i);
    ext_low = 1'b1;
    cyc(2);
    chk(hr_drive_o == 1'b0, "R8", "drive before sync delay", hr_drive_o, 0);
    cyc(1);
    chk(hr_drive_o == 1'b1, "R8", "drive after sync delay", hr_drive_o, 1);
    ext_low = 1'b0;
    cyc(120);
    chk(cfg_tot == c0, "R8", "no load on hard reset", cfg_tot - c0, 0);
    chk(abort_tot - a0 == 1, "R10", "single flow, no self retrigger", abort_tot - a0, 1);
    chk(last_run == H, "R6", "hard reset hold", last_run, H);

    // R10 outside agent still holding the line retriggers
    a0 = abort_tot;
    @(negedge clk_i);
    ext_low = 1'b1;
    cyc(100);
    ext_low = 1'b0;
    cyc(120);
    chk(abort_tot - a0 == 2, "R10", "retrigger while held", abort_tot - a0, 2);
    chk(hr_drive_o == 1'b0 && core_rst_o == 1'b0, "R9", "quiet at end",
        {hr_drive_o, core_rst_o}, 0);

    done = 1;
    report();
  end
endmodule